// File: doc/BRIEF.md
# Modulo Buffer Address Corrector

This block forms the effective address for one memory access of a data-memory address generator that supports circular buffers. Each request carries a pointer register's value and index, a signed step (the amount of a pre/post increment or decrement, or a register offset) and an addressing mode. The block also receives a buffer start address, a buffer end address, an enable and a pointer select. When the enable is set and the request's pointer index matches the select, any address that has stepped outside the buffer is folded back inside it.

Only the side of the buffer in the direction of travel is tested. A forward step is checked against the end address and a backward step against the start address. The tests are strict: an address equal to a boundary is already inside the buffer. Because of this, a step longer than one word that jumps past a boundary is still folded by exactly one buffer length.

The addressing mode decides which address goes to memory and whether the pointer register is rewritten. Results appear one cycle after the request, together with a valid strobe.

Top module: `modbuf_corrector`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle with `req_valid` high, and low after a cycle with `req_valid` low. After reset, `out_valid`, `out_ea`, `out_wb_en` and `out_wb_val` are all zero.
- R2: Correction applies only when `cfg_mod_en` is 1 and `req_ptr_idx` equals `cfg_mod_sel`. Otherwise the modified address is `req_ptr_val + req_step`, taken modulo 2^16, with no correction.
- R3: For a positive step, a modified address strictly greater than `cfg_buf_end` is reduced by the buffer length (`cfg_buf_end - cfg_buf_start + 1`). An address equal to the end address is left unchanged.
- R4: For a negative step (bit 15 of `req_step` set), a modified address strictly less than `cfg_buf_start` is increased by the buffer length. An address equal to the start address is left unchanged.
- R5: A zero step applies no correction, even when the pointer lies outside the buffer.
- R6: Pre-modify mode (`req_mode` = 0) gives `out_ea` = the corrected modified address, `out_wb_en` = 1 and `out_wb_val` = the corrected modified address.
- R7: Post-modify mode (`req_mode` = 1) gives `out_ea` = the unmodified pointer, `out_wb_en` = 1 and `out_wb_val` = the corrected modified address.
- R8: Offset mode (`req_mode` = 2, and also 3) gives `out_ea` = the corrected modified address, `out_wb_en` = 0 and `out_wb_val` = the unmodified pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_mode | input | 2 | 0 pre-modify, 1 post-modify, 2/3 offset |
| req_ptr_idx | input | 4 | Index of the pointer register used |
| req_ptr_val | input | 16 | Pointer register value (byte address) |
| req_step | input | 16 | Signed step or offset, two's complement |
| cfg_mod_en | input | 1 | Circular-buffer correction enable |
| cfg_mod_sel | input | 4 | Index of the pointer register subject to correction |
| cfg_buf_start | input | 16 | First byte address of the buffer |
| cfg_buf_end | input | 16 | Last byte address of the buffer |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_ea | output | 16 | Address used for the access |
| out_wb_en | output | 1 | Pointer register is to be rewritten |
| out_wb_val | output | 16 | Value for the pointer register |

## Verification
The pointer is swept across a 16-byte buffer and a few words on either side of it, with every even step from -20 to +20 and all three modes. This covers several kinds of result:
- landing exactly on either boundary, which shows the strict test apart from an inclusive one;
- stepping one word past a boundary;
- jumping well past a boundary, which shows one fold by the buffer length apart from clamping;
- zero steps from outside the buffer.

Each combination is repeated three ways: with correction active, with the enable cleared, and with a non-matching pointer index. This separates the enable and the select. A second, 8-byte buffer at a different base is swept the same way, so that a fixed length cannot pass as a computed one. An idle cycle checks that the strobe drops.

// File: rtl/modbuf_pkg.sv
// Package: shared addressing-mode encoding for the modulo address corrector.
// Assumes a 2-bit mode field; both upper codes mean base-plus-offset.
package modbuf_pkg;
    typedef enum logic [1:0] {
        AM_PRE     = 2'd0,
        AM_POST    = 2'd1,
        AM_OFFSET  = 2'd2,
        AM_OFFSET2 = 2'd3
    } addr_mode_e;
endpackage

// File: rtl/modbuf_fold.sv
// Module: folds a modified address back into [lo, hi] when it has left the
// buffer in the direction of the step. Assumes hi >= lo (unsigned) and a
// step smaller than the buffer length, so one fold is enough. Purely
// combinational.
module modbuf_fold #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr_in,
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    input  logic          enable,
    output logic [AW-1:0] addr_out,
    output logic          folded
);
    localparam int SIGN = AW - 1;

    logic [AW-1:0] buf_len;
    logic          step_up;
    logic          step_dn;
    logic          over_hi;
    logic          under_lo;

    // Purpose: buffer length and step direction.
    always_comb begin
        buf_len = hi - lo + AW'(1);
        step_dn = step[SIGN];
        step_up = !step[SIGN] && (step != '0);
    end

    // Purpose: strict boundary tests, only on the side being approached.
    always_comb begin
        over_hi  = enable && step_up && (addr_in > hi);
        under_lo = enable && step_dn && (addr_in < lo);
    end

    // Purpose: apply one buffer length of correction.
    always_comb begin
        if (over_hi)       addr_out = addr_in - buf_len;
        else if (under_lo) addr_out = addr_in + buf_len;
        else               addr_out = addr_in;
        folded = over_hi || under_lo;
    end
endmodule

// File: rtl/modbuf_outreg.sv
// Module: one-cycle output register with a valid strobe. Data is captured
// only on valid requests; everything clears on synchronous active-low reset.
module modbuf_outreg #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [AW-1:0] in_ea,
    input  logic          in_wb_en,
    input  logic [AW-1:0] in_wb_val,
    output logic          out_valid,
    output logic [AW-1:0] out_ea,
    output logic          out_wb_en,
    output logic [AW-1:0] out_wb_val
);
    // Purpose: strobe follows the request one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Purpose: hold the result of the last valid request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_ea     <= '0;
            out_wb_en  <= 1'b0;
            out_wb_val <= '0;
        end else if (in_valid) begin
            out_ea     <= in_ea;
            out_wb_en  <= in_wb_en;
            out_wb_val <= in_wb_val;
        end
    end

    // R1: the strobe tracks the request with one cycle of latency.
    p_strobe_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_strobe_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
endmodule

// File: rtl/modbuf_corrector.sv
// Module: top of the circular-buffer effective-address corrector. It adds the
// step to the pointer, folds the sum into the buffer when the request's
// pointer is the selected one and correction is enabled, and then picks the
// access address and writeback value by mode. Assumes byte addresses,
// cfg_buf_end >= cfg_buf_start, and |step| below the buffer length.
module modbuf_corrector
    import modbuf_pkg::*;
#(
    parameter int AW   = 16,
    parameter int SELW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [1:0]      req_mode,
    input  logic [SELW-1:0] req_ptr_idx,
    input  logic [AW-1:0]   req_ptr_val,
    input  logic [AW-1:0]   req_step,
    input  logic            cfg_mod_en,
    input  logic [SELW-1:0] cfg_mod_sel,
    input  logic [AW-1:0]   cfg_buf_start,
    input  logic [AW-1:0]   cfg_buf_end,
    output logic            out_valid,
    output logic [AW-1:0]   out_ea,
    output logic            out_wb_en,
    output logic [AW-1:0]   out_wb_val
);
    addr_mode_e    mode;
    logic          sel_hit;
    logic [AW-1:0] raw_sum;
    logic [AW-1:0] fixed_sum;
    logic          folded;
    logic [AW-1:0] nxt_ea;
    logic          nxt_wb_en;
    logic [AW-1:0] nxt_wb_val;

    // Purpose: decode mode, pointer match and the unmodified sum.
    always_comb begin
        mode    = addr_mode_e'(req_mode);
        sel_hit = cfg_mod_en && (req_ptr_idx == cfg_mod_sel);
        raw_sum = req_ptr_val + req_step;
    end

    modbuf_fold #(.AW(AW)) u_fold (
        .addr_in  (raw_sum),
        .step     (req_step),
        .lo       (cfg_buf_start),
        .hi       (cfg_buf_end),
        .enable   (sel_hit),
        .addr_out (fixed_sum),
        .folded   (folded)
    );

    // Purpose: choose the access address and writeback by addressing mode.
    always_comb begin
        unique case (mode)
            AM_PRE: begin
                nxt_ea     = fixed_sum;
                nxt_wb_en  = 1'b1;
                nxt_wb_val = fixed_sum;
            end
            AM_POST: begin
                nxt_ea     = req_ptr_val;
                nxt_wb_en  = 1'b1;
                nxt_wb_val = fixed_sum;
            end
            default: begin
                nxt_ea     = fixed_sum;
                nxt_wb_en  = 1'b0;
                nxt_wb_val = req_ptr_val;
            end
        endcase
    end

    modbuf_outreg #(.AW(AW)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (req_valid),
        .in_ea      (nxt_ea),
        .in_wb_en   (nxt_wb_en),
        .in_wb_val  (nxt_wb_val),
        .out_valid  (out_valid),
        .out_ea     (out_ea),
        .out_wb_en  (out_wb_en),
        .out_wb_val (out_wb_val)
    );

    // R2: a non-selected or disabled pointer sees plain modulo-2^16 sums.
    p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !sel_hit && req_mode != 2'd1)
        |=> out_ea == $past(req_ptr_val + req_step));
    // R3: a forward sum at or below the end address is not touched.
    p_hi_strict_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'd0 && !req_step[AW-1] && raw_sum <= cfg_buf_end)
        |=> out_ea == $past(raw_sum));
    // R4: a backward sum at or above the start address is not touched.
    p_lo_strict_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'd0 && req_step[AW-1] && raw_sum >= cfg_buf_start)
        |=> out_ea == $past(raw_sum));
    // R5: a zero step never folds.
    p_zero_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_step == '0) |-> !folded);
    // R7: post-modify accesses at the unmodified pointer and writes back.
    p_post_ea_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'd1)
        |=> (out_ea == $past(req_ptr_val)) && out_wb_en);
    // R8: offset mode keeps the pointer register unchanged.
    p_offset_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode[1])
        |=> !out_wb_en && (out_wb_val == $past(req_ptr_val)));
endmodule

// File: tb/modbuf_corrector_test.sv
module modbuf_corrector_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_mode = '0;
    logic [3:0]  req_ptr_idx = '0;
    logic [15:0] req_ptr_val = '0;
    logic [15:0] req_step = '0;
    logic        cfg_mod_en = 1'b0;
    logic [3:0]  cfg_mod_sel = 4'd5;
    logic [15:0] cfg_buf_start = 16'h0100;
    logic [15:0] cfg_buf_end = 16'h010F;
    logic        out_valid;
    logic [15:0] out_ea;
    logic        out_wb_en;
    logic [15:0] out_wb_val;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    modbuf_corrector uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_ptr_idx(req_ptr_idx), .req_ptr_val(req_ptr_val), .req_step(req_step),
        .cfg_mod_en(cfg_mod_en), .cfg_mod_sel(cfg_mod_sel),
        .cfg_buf_start(cfg_buf_start), .cfg_buf_end(cfg_buf_end),
        .out_valid(out_valid), .out_ea(out_ea), .out_wb_en(out_wb_en),
        .out_wb_val(out_wb_val)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Arithmetic model of the folded address.
    function automatic int model_sum(input int ptr, input int stp, input int lo,
                                     input int hi, input bit act, output string why);
        int s;
        s = ptr + stp;
        why = "R2";
        if (act) begin
            if (stp > 0 && s > hi) begin s = s - (hi - lo + 1); why = "R3"; end
            else if (stp < 0 && s < lo) begin s = s + (hi - lo + 1); why = "R4"; end
            else if (stp == 0) why = "R5";
            else why = (stp > 0) ? "R3" : "R4";
        end
        return s & 16'hFFFF;
    endfunction

    task automatic sweep(input int lo, input int hi);
        cfg_buf_start = 16'(lo);
        cfg_buf_end   = 16'(hi);
        for (int act = 0; act < 3; act++) begin
            for (int ptr = lo - 8; ptr <= hi + 9; ptr += 2) begin
                for (int stp = -20; stp <= 20; stp += 2) begin
                    for (int md = 0; md < 3; md++) begin
                        string why;
                        string tag;
                        int fs;
                        int e_ea;
                        int e_wb;
                        int e_wv;
                        bit on;
                        @(negedge clk);
                        req_valid   = 1'b1;
                        req_mode    = 2'(md);
                        req_ptr_val = 16'(ptr);
                        req_step    = 16'(stp);
                        cfg_mod_en  = (act != 1);
                        req_ptr_idx = (act == 2) ? 4'd3 : 4'd5;
                        on = (act == 0);
                        fs = model_sum(ptr, stp, lo, hi, on, why);
                        if (md == 0) begin e_ea = fs; e_wb = 1; e_wv = fs; tag = {"R6/", why}; end
                        else if (md == 1) begin e_ea = ptr; e_wb = 1; e_wv = fs; tag = {"R7/", why}; end
                        else begin e_ea = fs; e_wb = 0; e_wv = ptr; tag = {"R8/", why}; end
                        @(posedge clk);
                        @(negedge clk);
                        check({tag, " ea"}, int'(out_ea), e_ea);
                        check({tag, " wb_en"}, int'(out_wb_en), e_wb);
                        check({tag, " wb_val"}, int'(out_wb_val), e_wv);
                        check("R1 valid", int'(out_valid), 1);
                    end
                end
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset valid", int'(out_valid), 0);
        check("R1 reset ea", int'(out_ea), 0);
        check("R1 reset wb_en", int'(out_wb_en), 0);
        check("R1 reset wb_val", int'(out_wb_val), 0);
        rst_n = 1'b1;
        sweep(16'h0100, 16'h010F);
        sweep(16'h1230, 16'h1237);
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 idle valid", int'(out_valid), 0);
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 190000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule